// File: doc/BRIEF.md
# UART Receiver with Break Wake-up

This block receives asynchronous serial characters of one start bit, eight data bits sent least significant bit first, and one stop bit. It times every bit with a sample tick that runs at sixteen times the bit rate, and it validates each start bit half a bit after the falling edge. When a character is complete, the block presents the byte with a ready flag and a framing-error flag. It also raises a break indication when the character is all zeros and has no valid stop bit.

For low-power operation, software arms a wake mode with a one-cycle strobe. While the mode is armed, the receiver assembles nothing. The first falling edge on the synchronised line raises the ready flag and disarms the mode. The receiver then waits for the line to return high and receives the next character in the normal way. A one-cycle read strobe acknowledges a character or a wake event.

Top module: `uart_wake_rx`

## Requirements
- R1: During reset and right after it, rxReady, frameErr, breakDet and wakeEn are 0 and rxData is 0x00.
- R2: A character has a low start bit, then eight data bits (the first one received goes to rxData bit 0), then a stop bit. When it completes with a high stop bit, rxData holds the byte, rxReady is 1 and frameErr is 0.
- R3: When a character completes with a low stop bit, the byte is still loaded into rxData and frameErr is 1. frameErr is rewritten by every completed character.
- R4: breakDet is set when a character completes with data 0x00 and a low stop bit, and it is 0 after any other character. Whenever breakDet is 1, rxReady and frameErr are 1 and rxData is 0x00.
- R5: A pulse on dataRead clears rxReady and breakDet on the next clock edge, unless a character or a wake event completes in the same cycle. rxData and frameErr keep their values.
- R6: A pulse on wakeSet makes wakeEn 1 on the next clock edge. No other input and no line activity sets wakeEn.
- R7: While wakeEn is 1, no character is assembled. rxData and frameErr do not change, and rxReady rises only through the wake event.
- R8: While wakeEn is 1, a falling edge on rxIn sets rxReady and clears wakeEn on the third clock edge after the edge. The delay comes from a two-flop synchroniser and one registered event.
- R9: After a wake event, the receiver waits for the line to be high and then receives the next character normally.
- R10: After a character with a low stop bit, no new start bit is accepted until the line has been seen high. A line held low past the character therefore yields only one character.
- R11: All bit timing counts sampleTick pulses, 16 per bit, not clock cycles. Characters are received correctly when the tick arrives only every third clock.
- R12: A start bit is re-checked 8 ticks after it is detected. A low pulse shorter than that is discarded and produces no character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxIn | input | 1 | Serial receive line, idle high, asynchronous |
| sampleTick | input | 1 | One-cycle pulse at 16 times the bit rate |
| wakeSet | input | 1 | One-cycle strobe that arms the wake mode |
| dataRead | input | 1 | One-cycle strobe that acknowledges the received byte |
| rxData | output | 8 | Last received byte |
| rxReady | output | 1 | Character or wake event pending |
| frameErr | output | 1 | Stop bit of the last character was low |
| breakDet | output | 1 | Last character was a break |
| wakeEn | output | 1 | Wake mode armed |

## Verification
The wake event is the only result with an exact latency. rxReady rises and wakeEn falls on the third clock edge after rxIn drops, and the bench samples rxReady on the falling clock edges just before and just after that edge. A character result is due at the stop-bit sample point, a fixed number of ticks into the stop bit. The bench therefore checks each character only after the whole frame and an idle gap have been driven, when no later event can change it. Strobe effects are due one edge after the strobe, and the bench samples them on the following falling edge.

// File: rtl/uart_wake_pkg.sv
package uart_wake_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP,
    ST_HOLD,
    ST_SLEEP
  } rxState_t;

  // strobes from control to datapath, each one cycle wide
  typedef struct packed {
    logic shiftIn;   // take a data sample into the shift register
    logic loadChar;  // stop sample: publish byte and flags
    logic wakeHit;   // wake edge seen while armed
  } ctrlStrobes_t;

endpackage

// File: rtl/uart_wake_ctrl.sv
module uart_wake_ctrl
  import uart_wake_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_BITS  = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sampleTick,
  input  logic         rxSync,
  input  logic         rxFall,
  input  logic         wakeEn,
  output ctrlStrobes_t strb
);

  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam int IDX_W = $clog2(DATA_BITS);
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVERSAMPLE / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVERSAMPLE - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_BITS - 1);

  rxState_t         state, stateNext;
  logic [CNT_W-1:0] tickCnt, tickCntNext;
  logic [IDX_W-1:0] bitIdx, bitIdxNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else begin
      state   <= stateNext;
      tickCnt <= tickCntNext;
      bitIdx  <= bitIdxNext;
    end
  end

  always_comb begin
    stateNext   = state;
    tickCntNext = tickCnt;
    bitIdxNext  = bitIdx;
    strb        = '0;
    if (wakeEn && state != ST_SLEEP) begin
      // arming the wake mode abandons any character in progress
      stateNext   = ST_SLEEP;
      tickCntNext = '0;
      bitIdxNext  = '0;
    end else begin
      unique case (state)
        ST_SLEEP: begin
          if (!wakeEn) begin
            stateNext = ST_HOLD;
          end else if (rxFall) begin
            strb.wakeHit = 1'b1;
            stateNext    = ST_HOLD;
          end
        end
        ST_IDLE: begin
          if (sampleTick && !rxSync) begin
            stateNext   = ST_START;
            tickCntNext = '0;
          end
        end
        ST_START: begin
          if (sampleTick) begin
            if (tickCnt == MID_CNT) begin
              tickCntNext = '0;
              bitIdxNext  = '0;
              stateNext   = rxSync ? ST_IDLE : ST_DATA;
            end else begin
              tickCntNext = tickCnt + 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (sampleTick) begin
            if (tickCnt == LAST_CNT) begin
              strb.shiftIn = 1'b1;
              tickCntNext  = '0;
              if (bitIdx == LAST_IDX) stateNext = ST_STOP;
              else bitIdxNext = bitIdx + 1'b1;
            end else begin
              tickCntNext = tickCnt + 1'b1;
            end
          end
        end
        ST_STOP: begin
          if (sampleTick) begin
            if (tickCnt == LAST_CNT) begin
              strb.loadChar = 1'b1;
              tickCntNext   = '0;
              stateNext     = rxSync ? ST_IDLE : ST_HOLD;
            end else begin
              tickCntNext = tickCnt + 1'b1;
            end
          end
        end
        ST_HOLD: begin
          if (rxSync) stateNext = ST_IDLE;
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/uart_wake_dp.sv
module uart_wake_dp
  import uart_wake_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxIn,
  input  ctrlStrobes_t         strb,
  input  logic                 wakeSet,
  input  logic                 dataRead,
  output logic                 rxSync,
  output logic                 rxFall,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxReady,
  output logic                 frameErr,
  output logic                 breakDet,
  output logic                 wakeEn
);

  logic [1:0]           syncReg;
  logic                 rxPrev;
  logic [DATA_BITS-1:0] shiftReg;

  assign rxSync = syncReg[1];
  assign rxFall = rxPrev & ~rxSync;

  // two-flop synchroniser plus edge history, idle level high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncReg <= 2'b11;
      rxPrev  <= 1'b1;
    end else begin
      syncReg <= {syncReg[0], rxIn};
      rxPrev  <= rxSync;
    end
  end

  // first bit received ends up at bit 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (strb.shiftIn) shiftReg <= {rxSync, shiftReg[DATA_BITS-1:1]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData   <= '0;
      frameErr <= 1'b0;
    end else if (strb.loadChar) begin
      rxData   <= shiftReg;
      frameErr <= ~rxSync;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) breakDet <= 1'b0;
    else if (strb.loadChar) breakDet <= ~rxSync && (shiftReg == '0);
    else if (dataRead) breakDet <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxReady <= 1'b0;
    else if (strb.loadChar || strb.wakeHit) rxReady <= 1'b1;
    else if (dataRead) rxReady <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wakeEn <= 1'b0;
    else if (wakeSet) wakeEn <= 1'b1;
    else if (strb.wakeHit) wakeEn <= 1'b0;
  end

endmodule

// File: rtl/uart_wake_rx.sv
module uart_wake_rx
  import uart_wake_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_BITS  = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxIn,
  input  logic                 sampleTick,
  input  logic                 wakeSet,
  input  logic                 dataRead,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxReady,
  output logic                 frameErr,
  output logic                 breakDet,
  output logic                 wakeEn
);

  ctrlStrobes_t strb;
  logic         rxSync;
  logic         rxFall;

  uart_wake_ctrl #(
    .OVERSAMPLE(OVERSAMPLE),
    .DATA_BITS (DATA_BITS)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sampleTick(sampleTick),
    .rxSync    (rxSync),
    .rxFall    (rxFall),
    .wakeEn    (wakeEn),
    .strb      (strb)
  );

  uart_wake_dp #(
    .DATA_BITS(DATA_BITS)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .rxIn    (rxIn),
    .strb    (strb),
    .wakeSet (wakeSet),
    .dataRead(dataRead),
    .rxSync  (rxSync),
    .rxFall  (rxFall),
    .rxData  (rxData),
    .rxReady (rxReady),
    .frameErr(frameErr),
    .breakDet(breakDet),
    .wakeEn  (wakeEn)
  );

endmodule

// File: rtl/uart_wake_rx_chk.sv
module uart_wake_rx_chk
  import uart_wake_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 wakeSet,
  input logic                 dataRead,
  input logic [DATA_BITS-1:0] rxData,
  input logic                 rxReady,
  input logic                 frameErr,
  input logic                 breakDet,
  input logic                 wakeEn,
  input ctrlStrobes_t         strb
);

  p_wake_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    wakeSet |=> wakeEn);

  p_wake_source_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakeEn) |-> $past(wakeSet));

  p_sleep_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    wakeEn |=> ($stable(rxData) && $stable(frameErr)));

  p_wake_event_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wakeHit && !wakeSet) |=> (!wakeEn && rxReady));

  p_read_clears_r5: assert property (@(posedge clk) disable iff (!rstN)
    (dataRead && !strb.loadChar && !strb.wakeHit) |=> (!rxReady && !breakDet));

  p_break_flags_r4: assert property (@(posedge clk) disable iff (!rstN)
    breakDet |-> (rxReady && frameErr && rxData == '0));

  p_ready_source_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxReady) |-> $past(strb.loadChar || strb.wakeHit));

endmodule

bind uart_wake_rx uart_wake_rx_chk #(.DATA_BITS(DATA_BITS)) i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wakeSet (wakeSet),
  .dataRead(dataRead),
  .rxData  (rxData),
  .rxReady (rxReady),
  .frameErr(frameErr),
  .breakDet(breakDet),
  .wakeEn  (wakeEn),
  .strb    (strb)
);

// File: tb/test_uart_wake_rx.sv
`timescale 1ns/1ps
module test_uart_wake_rx;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxIn = 1'b1;
  logic       sampleTick = 1'b0;
  logic       wakeSet = 1'b0;
  logic       dataRead = 1'b0;
  logic [7:0] rxData;
  logic       rxReady, frameErr, breakDet, wakeEn;

  int checks = 0;
  int errors = 0;
  int tickDiv = 1;
  int divCnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  uart_wake_rx i_uart_wake_rx (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .sampleTick(sampleTick),
    .wakeSet(wakeSet), .dataRead(dataRead), .rxData(rxData),
    .rxReady(rxReady), .frameErr(frameErr), .breakDet(breakDet),
    .wakeEn(wakeEn)
  );

  always @(negedge clk) begin
    if (divCnt >= tickDiv - 1) begin
      divCnt     <= 0;
      sampleTick <= 1'b1;
    end else begin
      divCnt     <= divCnt + 1;
      sampleTick <= 1'b0;
    end
  end

  // {byte, stop bit, expected frameErr, expected breakDet}
  localparam logic [10:0] VEC [8] = '{
    {8'h55, 1'b1, 1'b0, 1'b0},
    {8'hA3, 1'b1, 1'b0, 1'b0},
    {8'hFF, 1'b1, 1'b0, 1'b0},
    {8'h00, 1'b1, 1'b0, 1'b0},
    {8'h00, 1'b0, 1'b1, 1'b1},
    {8'h81, 1'b0, 1'b1, 1'b0},
    {8'h3C, 1'b1, 1'b0, 1'b0},
    {8'h01, 1'b1, 1'b0, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic waitBits(input int n);
    repeat (n * 16 * tickDiv) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] b, input logic stopBit);
    @(negedge clk);
    rxIn = 1'b0;
    waitBits(1);
    for (int i = 0; i < 8; i++) begin
      rxIn = b[i];
      waitBits(1);
    end
    rxIn = stopBit;
    waitBits(1);
    rxIn = 1'b1;
    repeat (8 * tickDiv) @(negedge clk);
  endtask

  task automatic readPulse();
    @(negedge clk);
    dataRead = 1'b1;
    @(negedge clk);
    dataRead = 1'b0;
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual running expected finished");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rxReady", rxReady, 0);
    check("R1 frameErr", frameErr, 0);
    check("R1 breakDet", breakDet, 0);
    check("R1 wakeEn", wakeEn, 0);
    check("R1 rxData", rxData, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after reset rxReady", rxReady, 0);

    // vector table: R2 data, R3 framing, R4 break, R5 read
    for (int v = 0; v < 8; v++) begin
      sendFrame(VEC[v][10:3], VEC[v][2]);
      check("R2 rxReady", rxReady, 1);
      check("R2 rxData", rxData, VEC[v][10:3]);
      check("R3 frameErr", frameErr, VEC[v][1]);
      check("R4 breakDet", breakDet, VEC[v][0]);
      readPulse();
      check("R5 rxReady cleared", rxReady, 0);
      check("R5 breakDet cleared", breakDet, 0);
      check("R5 rxData kept", rxData, VEC[v][10:3]);
      check("R5 frameErr kept", frameErr, VEC[v][1]);
    end
    check("R6 wakeEn not set by traffic", wakeEn, 0);

    // R12: short low glitch is discarded
    @(negedge clk);
    rxIn = 1'b0;
    repeat (4) @(negedge clk);
    rxIn = 1'b1;
    repeat (300) @(negedge clk);
    check("R12 glitch rxReady", rxReady, 0);

    // R11: slower tick
    tickDiv = 3;
    repeat (6) @(negedge clk);
    sendFrame(8'h96, 1'b1);
    check("R11 rxReady", rxReady, 1);
    check("R11 rxData", rxData, 8'h96);
    readPulse();
    tickDiv = 1;
    repeat (6) @(negedge clk);

    // R10: long low yields one character, then normal reception
    @(negedge clk);
    rxIn = 1'b0;
    waitBits(10);
    check("R10 break rxReady", rxReady, 1);
    check("R10 break frameErr", frameErr, 1);
    check("R10 break breakDet", breakDet, 1);
    readPulse();
    waitBits(3);
    rxIn = 1'b1;
    repeat (40) @(negedge clk);
    check("R10 no second character", rxReady, 0);
    sendFrame(8'h5A, 1'b1);
    check("R10 next rxData", rxData, 8'h5A);
    check("R10 next frameErr", frameErr, 0);
    readPulse();

    // R6 / R7 / R8 / R9: wake mode
    @(negedge clk);
    wakeSet = 1'b1;
    @(negedge clk);
    wakeSet = 1'b0;
    check("R6 wakeEn set", wakeEn, 1);
    repeat (200) @(negedge clk);
    check("R7 idle while armed", rxReady, 0);
    rxIn = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R8 not yet after two edges", rxReady, 0);
    check("R8 still armed after two edges", wakeEn, 1);
    @(negedge clk);
    check("R8 wake sets rxReady", rxReady, 1);
    check("R8 wake clears wakeEn", wakeEn, 0);
    waitBits(12);
    check("R7 rxData untouched", rxData, 8'h5A);
    check("R7 frameErr untouched", frameErr, 0);
    rxIn = 1'b1;
    readPulse();
    check("R5 wake flag cleared by read", rxReady, 0);
    repeat (10) @(negedge clk);
    sendFrame(8'hC3, 1'b1);
    check("R9 rxReady after wake", rxReady, 1);
    check("R9 rxData after wake", rxData, 8'hC3);
    check("R9 frameErr after wake", frameErr, 0);

    done = 1'b1;
    finishRun();
  end

endmodule